// File: doc/BRIEF.md
# I2C Bus Clear Sequencer

This block frees an I2C bus that a target is holding stuck by keeping SDA low, for example after a reset that arrived in the middle of a read. When the engine is armed it leaves SDA released and toggles SCL a programmed number of times, so that the target can shift out whatever byte it was sending and let go of the line. It stops early as soon as SDA reads high at the end of a clock pulse. It can also finish with a stop condition so that the target's state machine returns to idle. Both outputs are open-drain controls: a 1 on `scl_oe` or `sda_oe` pulls that line low.

Software writes the settings into shadow registers: enable, stop option, pulse count and phase divisor. The settings take effect only when a load strobe is applied. The strobe stays pending until the engine is idle and then clears itself. When the sequence ends, the block sets a sticky completion interrupt and a status bit telling whether SDA was found released. The enable bit clears itself at the same moment, and software clears the interrupt with a write-one-to-clear pulse.

Top module: `i2c_bus_recover`

## Requirements
- R1: Writes to the shadow settings (`cfg_we`) have no effect on the bus, on `busy` or on a sequence already running until a load strobe is applied.
- R2: While `busy` is 0, `scl_oe` and `sda_oe` are both 0. After reset, `busy`, `en_live`, `done_irq`, `sda_freed` and `load_pend` are all 0.
- R3: `load_req` sets `load_pend`. A pending load is held while `busy` is 1. It is applied and cleared in the first clock the engine is idle, and then starts a sequence with the newly loaded settings.
- R4: When a load is applied with enable=1 and a count of N>0, and the target keeps SDA low, SCL is driven low and released exactly N times while `sda_oe` stays 0.
- R5: Every SCL low phase and every SCL high phase of the recovery pulses lasts `cfg_div`+1 clock cycles.
- R6: SDA is sampled at the end of each SCL high phase. If it reads 1, no further pulse follows. `sda_freed` is set to the value SDA has when the sequence finishes: 1 if released, 0 if still held.
- R7: With the stop option set, the sequence continues after the last pulse as follows, each step lasting one phase: SCL driven low, SDA driven low, SCL released, SDA released. SDA is released while SCL is released, which forms a stop, and `sda_oe` changes only while SCL is driven low except at that stop edge.
- R8: `done_irq` is set when a sequence finishes and stays 1 until a `done_clr` pulse. A completion in the same cycle as a clear leaves it set.
- R9: `en_live` becomes 1 when a sequence starts and returns to 0 in the same clock in which `done_irq` is set.
- R10: Applying a load with enable=0 starts nothing. Applying enable=1 with a count of 0 produces no pulse and finishes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the shadow settings |
| cfg_enable | input | 1 | Shadow enable bit |
| cfg_stop | input | 1 | Shadow option to end with a stop condition |
| cfg_pulses | input | CNT_W | Shadow number of SCL pulses |
| cfg_div | input | DIV_W | Shadow phase length minus one, in clocks |
| load_req | input | 1 | Config-load strobe |
| load_pend | output | 1 | Load requested and not yet applied |
| done_clr | input | 1 | Write-one-to-clear pulse for `done_irq` |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Sequence in progress |
| en_live | output | 1 | Live enable, clears itself on completion |
| done_irq | output | 1 | Sticky completion interrupt |
| sda_freed | output | 1 | 1 if SDA read high when the last sequence finished |

## Verification
The checker watches the following rules on every cycle: the bus lines stay quiet while idle, a pending load survives a busy period, SDA only starts being driven while SCL is held low and is only let go for the stop, the interrupt stays set until cleared, and the enable has already dropped when completion rises. The pulse count, the phase length, the early exit at the pulse where the target lets go, the value of the status bit and the fact that the new settings apply only after the strobe depend on a whole scenario. The bench shows these by playing a target model against a table of settings and counting SCL releases.

// File: rtl/i2cbc_pkg.sv
package i2cbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_SCLLO = 3'd4,
    ST_SDALO = 3'd5,
    ST_SCLHI = 3'd6,
    ST_SDAHI = 3'd7
  } bc_state_e;
endpackage

// File: rtl/i2cbc_cfg.sv
module i2cbc_cfg #(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_enable,
  input  logic             cfg_stop,
  input  logic [CNT_W-1:0] cfg_pulses,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             load_req,
  input  logic             idle,
  output logic             load_pend,
  output logic             start,
  output logic             act_stop,
  output logic [CNT_W-1:0] act_pulses,
  output logic [DIV_W-1:0] act_div
);
  logic             sh_en_q, sh_stop_q;
  logic [CNT_W-1:0] sh_cnt_q;
  logic [DIV_W-1:0] sh_div_q;
  logic             pend_q, pend_d, apply;

  assign apply     = pend_q & idle;
  assign start     = apply & sh_en_q;
  assign pend_d    = load_req | (pend_q & ~apply);
  assign load_pend = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en_q   <= 1'b0;
      sh_stop_q <= 1'b0;
      sh_cnt_q  <= '0;
      sh_div_q  <= '0;
    end else if (cfg_we) begin
      sh_en_q   <= cfg_enable;
      sh_stop_q <= cfg_stop;
      sh_cnt_q  <= cfg_pulses;
      sh_div_q  <= cfg_div;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_stop   <= 1'b0;
      act_pulses <= '0;
      act_div    <= '0;
    end else if (apply) begin
      act_stop   <= sh_stop_q;
      act_pulses <= sh_cnt_q;
      act_div    <= sh_div_q;
    end
  end
endmodule

// File: rtl/i2cbc_timer.sv
module i2cbc_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == div);

  always_comb begin
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cbc_fsm.sv
module i2cbc_fsm
  import i2cbc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             act_stop,
  input  logic [CNT_W-1:0] act_pulses,
  input  logic             tick,
  input  logic             sda_in,
  input  logic             done_clr,
  output logic             idle,
  output logic             timer_clr,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             en_live,
  output logic             done_irq,
  output logic             sda_freed
);
  bc_state_e        st_q, st_d;
  logic [CNT_W-1:0] pc_q, pc_d, pc_inc;
  logic             en_d, done_set, freed_d;

  assign pc_inc    = pc_q + 1'b1;
  assign idle      = (st_q == ST_IDLE);
  assign timer_clr = (st_q == ST_IDLE) || (st_q == ST_ARM);
  assign scl_oe    = (st_q == ST_LOW) || (st_q == ST_SCLLO) || (st_q == ST_SDALO);
  assign sda_oe    = (st_q == ST_SDALO) || (st_q == ST_SCLHI);

  always_comb begin
    st_d     = st_q;
    pc_d     = pc_q;
    en_d     = en_live;
    done_set = 1'b0;
    freed_d  = sda_freed;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_ARM;
        pc_d = '0;
        en_d = 1'b1;
      end
      ST_ARM: begin
        if (act_pulses != '0) st_d = ST_LOW;
        else if (act_stop)    st_d = ST_SCLLO;
        else begin
          st_d = ST_IDLE; done_set = 1'b1; freed_d = sda_in; en_d = 1'b0;
        end
      end
      ST_LOW: if (tick) st_d = ST_HIGH;
      ST_HIGH: if (tick) begin
        pc_d = pc_inc;
        if (sda_in || (pc_inc == act_pulses)) begin
          if (act_stop) st_d = ST_SCLLO;
          else begin
            st_d = ST_IDLE; done_set = 1'b1; freed_d = sda_in; en_d = 1'b0;
          end
        end else begin
          st_d = ST_LOW;
        end
      end
      ST_SCLLO: if (tick) st_d = ST_SDALO;
      ST_SDALO: if (tick) st_d = ST_SCLHI;
      ST_SCLHI: if (tick) st_d = ST_SDAHI;
      ST_SDAHI: if (tick) begin
        st_d = ST_IDLE; done_set = 1'b1; freed_d = sda_in; en_d = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      pc_q      <= '0;
      en_live   <= 1'b0;
      sda_freed <= 1'b0;
      done_irq  <= 1'b0;
    end else begin
      st_q      <= st_d;
      pc_q      <= pc_d;
      en_live   <= en_d;
      sda_freed <= freed_d;
      if (done_set)      done_irq <= 1'b1;
      else if (done_clr) done_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover #(
  parameter int CNT_W   = 8,
  parameter int DIV_W   = 8,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_enable,
  input  logic             cfg_stop,
  input  logic [CNT_W-1:0] cfg_pulses,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             load_req,
  output logic             load_pend,
  input  logic             done_clr,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             en_live,
  output logic             done_irq,
  output logic             sda_freed
);
  localparam int SYNC_MSB = SYNC_N - 1;

  logic [SYNC_MSB:0] rst_sync_q;
  logic              rst_n_s;
  logic              idle, start, tick, timer_clr, act_stop;
  logic [CNT_W-1:0]  act_pulses;
  logic [DIV_W-1:0]  act_div;

  generate
    if (SYNC_N > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_MSB-1:0], 1'b1};
      end
    end else begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end
  endgenerate

  assign rst_n_s = rst_sync_q[SYNC_MSB];
  assign busy    = ~idle;

  i2cbc_cfg #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s),
    .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_stop(cfg_stop),
    .cfg_pulses(cfg_pulses), .cfg_div(cfg_div),
    .load_req(load_req), .idle(idle), .load_pend(load_pend), .start(start),
    .act_stop(act_stop), .act_pulses(act_pulses), .act_div(act_div)
  );

  i2cbc_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .clr(timer_clr), .div(act_div), .tick(tick)
  );

  i2cbc_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .start(start), .act_stop(act_stop),
    .act_pulses(act_pulses), .tick(tick), .sda_in(sda_in), .done_clr(done_clr),
    .idle(idle), .timer_clr(timer_clr), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .en_live(en_live), .done_irq(done_irq), .sda_freed(sda_freed)
  );
endmodule

// File: rtl/i2cbc_checker.sv
module i2cbc_checker (
  input logic clk,
  input logic rst_n,
  input logic load_pend,
  input logic done_clr,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic en_live,
  input logic done_irq
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe)); // R2
  AST_LOAD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pend && busy) |=> load_pend); // R3
  AST_SDA_GRAB_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> scl_oe); // R7
  AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_oe); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !done_clr) |=> done_irq); // R8
  AST_ENABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> !en_live); // R9
endmodule

bind i2c_bus_recover i2cbc_checker u_chk (
  .clk(clk), .rst_n(rst_n_s), .load_pend(load_pend), .done_clr(done_clr),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .en_live(en_live),
  .done_irq(done_irq)
);

// File: tb/sim_i2c_bus_recover.sv
module sim_i2c_bus_recover;
  logic       clk, rst_n;
  logic       cfg_we, cfg_enable, cfg_stop, load_req, done_clr;
  logic [7:0] cfg_pulses, cfg_div;
  logic       load_pend, scl_oe, sda_oe, busy, en_live, done_irq, sda_freed;
  logic       sda_in;

  int total = 0, fails = 0;
  int pcnt, low_run, low_len, rel;
  logic tgt_hold, stop_seen, p_scl, p_sda, p_busy;

  assign sda_in = !sda_oe && !tgt_hold;

  i2c_bus_recover u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
    .cfg_stop(cfg_stop), .cfg_pulses(cfg_pulses), .cfg_div(cfg_div),
    .load_req(load_req), .load_pend(load_pend), .done_clr(done_clr),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
    .en_live(en_live), .done_irq(done_irq), .sda_freed(sda_freed)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {pulses[33:26], stop[25], div[24:17], release_after[16:9], exp_pulses[8:1], exp_freed[0]}
  localparam logic [33:0] VEC [6] = '{
    {8'd9, 1'b0, 8'd1, 8'd0, 8'd9, 1'b0},
    {8'd9, 1'b0, 8'd2, 8'd3, 8'd3, 1'b1},
    {8'd5, 1'b1, 8'd0, 8'd0, 8'd5, 1'b0},
    {8'd9, 1'b1, 8'd3, 8'd2, 8'd2, 1'b1},
    {8'd1, 1'b0, 8'd0, 8'd1, 8'd1, 1'b1},
    {8'd0, 1'b0, 8'd1, 8'd0, 8'd0, 1'b0}
  };

  // target model and bus monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      pcnt = 0; low_run = 0; low_len = 0; stop_seen = 0; tgt_hold = 1;
    end else begin
      if (busy && !p_busy) begin
        pcnt = 0; low_run = 0; low_len = 0; stop_seen = 0; tgt_hold = 1;
      end
      if (p_scl && !scl_oe && !sda_oe) begin
        pcnt = pcnt + 1;
        low_len = low_run;
        if (rel != 0 && pcnt == rel) tgt_hold = 0;
      end
      if (p_sda && !sda_oe && !scl_oe) stop_seen = 1;
      if (scl_oe && !sda_oe) low_run = low_run + 1; else low_run = 0;
    end
    p_scl = scl_oe; p_sda = sda_oe; p_busy = busy;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic en, input logic stp, input int n, input int d);
    cfg_enable = en; cfg_stop = stp; cfg_pulses = n[7:0]; cfg_div = d[7:0];
    cfg_we = 1; @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_load();
    load_req = 1; @(negedge clk); load_req = 0;
  endtask

  task automatic clear_done();
    done_clr = 1; @(negedge clk); done_clr = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done_irq) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit ok;
    rst_n = 0; cfg_we = 0; cfg_enable = 0; cfg_stop = 0; cfg_pulses = 0;
    cfg_div = 0; load_req = 0; done_clr = 0; rel = 0;
    p_scl = 0; p_sda = 0; p_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 reset state
    chk("R2 busy", busy, 0);
    chk("R2 scl_oe", scl_oe, 0);
    chk("R2 sda_oe", sda_oe, 0);
    chk("R2 done_irq", done_irq, 0);
    chk("R2 en_live", en_live, 0);
    chk("R2 load_pend", load_pend, 0);

    // R1 shadow write alone does nothing
    write_cfg(1, 0, 4, 0);
    repeat (20) @(negedge clk);
    chk("R1 no start busy", busy, 0);
    chk("R1 no pulses", pcnt, 0);
    chk("R1 no done", done_irq, 0);

    // R10 enable=0 load
    write_cfg(0, 0, 4, 0);
    pulse_load();
    repeat (20) @(negedge clk);
    chk("R10 disabled busy", busy, 0);
    chk("R10 disabled done", done_irq, 0);
    chk("R3 load applied when idle", load_pend, 0);

    // table of runs: R4 R5 R6 R7 R9 R10
    foreach (VEC[k]) begin
      rel = int'(VEC[k][16:9]);
      write_cfg(1, VEC[k][25], int'(VEC[k][33:26]), int'(VEC[k][24:17]));
      pulse_load();
      wait_done(ok);
      chk("R8 done raised", ok, 1);
      chk("R4 R6 pulse count", pcnt, int'(VEC[k][8:1]));
      chk("R6 sda_freed", sda_freed, VEC[k][0]);
      chk("R7 stop formed", stop_seen, VEC[k][25]);
      chk("R9 en_live cleared", en_live, 0);
      if (VEC[k][33:26] != 0)
        chk("R5 low phase length", low_len, int'(VEC[k][24:17]) + 1);
      else
        chk("R10 zero count no pulse", pcnt, 0);
      clear_done();
      chk("R8 done cleared", done_irq, 0);
    end

    // R3 R1: load during a run waits, and new shadow does not alter the run
    rel = 0;
    write_cfg(1, 0, 9, 3);
    pulse_load();
    repeat (12) @(negedge clk);
    chk("R3 busy during run", busy, 1);
    write_cfg(1, 0, 2, 0);
    pulse_load();
    repeat (5) @(negedge clk);
    chk("R3 load held while busy", load_pend, 1);
    wait_done(ok);
    chk("R1 running count unchanged", pcnt, 9);
    // R8 sticky
    repeat (2) @(negedge clk);
    chk("R8 done sticky", done_irq, 1);
    clear_done();
    chk("R8 cleared by write", done_irq, 0);
    wait_done(ok);
    chk("R3 second run after pending load", pcnt, 2);
    chk("R3 pend cleared", load_pend, 0);
    clear_done();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule